// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block is the addressing layer of a slave on a single-wire, open-drain bus. Below it, a time-slot engine turns line activity into single-cycle events: a bus reset (flagged as long when its width was of standard-speed length), a bit written by the master, or a read slot opened by the master. Above it, a memory or function layer may run only while this block asserts `selected`. The block also drives `overdrive`, which tells the slot engine to use the fast timing set.

After every bus reset the layer takes an 8-bit command, least significant bit first. Depending on that command it streams out its 64-bit identity, compares a received identity against its own, takes part in a bitwise arbitration search, selects itself without addressing, re-selects itself by way of a resume flag, or does either of the last two while switching to fast timing. The 64-bit identity is made of a 56-bit body taken from an input and a top byte of CRC-8 that the block computes over that body.

A resume flag remembers whether the last addressing command selected this slave individually. It lets the master re-address the same slave with one short command after a reset, without sending the identity again.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_n` or a `bus_reset` pulse, `selected` is 0, `tx_bit` is 1 (line released) and the layer waits for a new 8-bit command received LSB first.
- R2: Command 33h sends the 64 identity bits, LSB first, one per `rd_slot` pulse; `tx_bit` shows the next bit to go out, and `selected` rises once the 64th slot has passed.
- R3: Identity bits 55:0 equal `rom_id_in`; bits 63:56 hold the CRC-8 of those 56 bits (polynomial x^8+x^5+x^4+1, bit-reversed form 8Ch, initial value 0, bit 0 first).
- R4: Command 55h is followed by 64 written bits, LSB first. `selected` rises only if every bit equals the identity. On the first mismatch the slave goes silent until the next bus reset.
- R5: Command F0h runs 64 rounds. In round n the slave sends identity bit n, then its complement, and then reads one master bit. A master bit that differs from bit n makes the slave drop out until reset. After round 63 the slave is selected.
- R6: Command CCh selects the slave with no addressing and clears the resume flag.
- R7: Command A5h selects the slave only if the resume flag is set. Commands 33h, 55h, F0h and CCh clear the flag when they are decoded. A successful 33h, 55h or F0h sets it. If the flag is clear, A5h acts like an unknown command.
- R8: The resume flag is kept across bus resets and is cleared only by `rst_n`.
- R9: Command 3Ch selects the slave and sets `overdrive`.
- R10: Command 69h sets `overdrive` at once and then takes a 64-bit identity as in R4. On a full match the slave is selected and stays in overdrive. On a mismatch `overdrive` goes back to the value it had before the command.
- R11: A bus reset with `reset_long` high clears `overdrive`. A short bus reset leaves it unchanged.
- R12: Any other command byte makes the slave ignore all written bits and read slots (`tx_bit` stays 1, `selected` stays 0) until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: a bus reset was seen |
| reset_long | input | 1 | Qualifies `bus_reset`: its width was of standard-speed length |
| rx_valid | input | 1 | One-cycle pulse: the master wrote a bit |
| rx_bit | input | 1 | Value of the written bit |
| rd_slot | input | 1 | One-cycle pulse: a master read slot consumed `tx_bit` |
| rom_id_in | input | 56 | Identity body (family code and serial) |
| tx_bit | output | 1 | Bit to drive in the next read slot (1 = release) |
| selected | output | 1 | The higher layer may run |
| overdrive | output | 1 | The slot engine should use fast timing |

## Verification
The bench checks the failure modes that would break arbitration or selection on a shared bus. A mismatch in the last identity bit must leave the slave unselected; a design that tests only the early bits would select the wrong device. In a search, the complement must follow the true bit, and after a wrong master bit the slave must go quiet; otherwise it would corrupt the wired-AND result for every other slave on the bus. The bench also checks the resume flag after Skip, after a failed Match and after a power-on reset, where a design that kept a stale flag would answer a Resume it should ignore. It checks that a failed fast-speed Match returns `overdrive` to its earlier value and does not simply clear it, and that a short reset keeps fast timing while a long reset clears it.

// File: rtl/owr_pkg.sv
package owr_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SEARCH,
      ST_SEL,
      ST_IDLE
   } owr_state_e;

   typedef enum logic [1:0] {
      PH_SEND,
      PH_CMPL,
      PH_RECV
   } owr_phase_e;

   localparam logic [7:0] OP_READ_ID  = 8'h33;
   localparam logic [7:0] OP_MATCH    = 8'h55;
   localparam logic [7:0] OP_SEARCH   = 8'hF0;
   localparam logic [7:0] OP_SKIP     = 8'hCC;
   localparam logic [7:0] OP_RESUME   = 8'hA5;
   localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
   localparam logic [7:0] OP_OD_MATCH = 8'h69;

endpackage

// File: rtl/owr_crc8.sv
module owr_crc8 #(
   parameter int DATA_W = 56,
   parameter int CRC_W = 8,
   parameter logic [CRC_W-1:0] POLY_REV = 8'h8C
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);

   logic [CRC_W-1:0] chain [0:DATA_W];

   assign chain[0] = '0;

   for (genvar i = 0; i < DATA_W; i++) begin : g_step
      logic fb;
      assign fb = chain[i][0] ^ data_i[i];
      assign chain[i+1] = (chain[i] >> 1) ^ (fb ? POLY_REV : '0);
   end

   assign crc_o = chain[DATA_W];

endmodule

// File: rtl/owr_cmd_shift.sv
module owr_cmd_shift #(
   parameter int CMD_W = 8,
   localparam int CNT_W = $clog2(CMD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             rx_valid,
   input  logic             rx_bit,
   output logic             done,
   output logic [CMD_W-1:0] byte_o
);

   logic [CNT_W-1:0] cnt;
   logic [CMD_W-2:0] sr;
   logic             last;

   assign last   = (cnt == CNT_W'(CMD_W - 1));
   assign done   = en && !clear && rx_valid && last;
   assign byte_o = {rx_bit, sr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '0;
      end else if (clear || !en) begin
         cnt <= '0;
      end else if (rx_valid) begin
         sr  <= {rx_bit, sr[CMD_W-2:1]};
         cnt <= last ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
   import owr_pkg::*;
#(
   parameter int ID_W   = 64,
   parameter int CRC_W  = 8,
   parameter int CMD_W  = 8,
   parameter bit HAS_OD = 1'b1,
   localparam int BODY_W = ID_W - CRC_W,
   localparam int IDX_W  = $clog2(ID_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_reset,
   input  logic              reset_long,
   input  logic              rx_valid,
   input  logic              rx_bit,
   input  logic              rd_slot,
   input  logic [BODY_W-1:0] rom_id_in,
   output logic              tx_bit,
   output logic              selected,
   output logic              overdrive
);

   if (ID_W <= CRC_W) begin : g_bad_id_w
      $error("ID_W must exceed CRC_W");
   end
   if (CMD_W != 8) begin : g_bad_cmd_w
      $error("command opcodes are 8 bits wide");
   end

   owr_state_e       st;
   owr_phase_e       ph;
   logic [IDX_W-1:0] idx;
   logic             rc;
   logic [CRC_W-1:0] crc;
   logic [ID_W-1:0]  full_id;
   logic             id_bit;
   logic             idx_last;
   logic             cmd_done;
   logic [CMD_W-1:0] cmd_byte;
   logic             od_save;
   logic             od_raise;
   logic             od_restore;

   owr_crc8 #(.DATA_W(BODY_W), .CRC_W(CRC_W)) u_crc (
      .data_i (rom_id_in),
      .crc_o  (crc)
   );

   assign full_id  = {crc, rom_id_in};
   assign id_bit   = full_id[idx];
   assign idx_last = (idx == IDX_W'(ID_W - 1));

   owr_cmd_shift #(.CMD_W(CMD_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (bus_reset),
      .en       (st == ST_CMD),
      .rx_valid (rx_valid),
      .rx_bit   (rx_bit),
      .done     (cmd_done),
      .byte_o   (cmd_byte)
   );

   // overdrive control strobes
   always_comb begin
      od_save    = 1'b0;
      od_raise   = 1'b0;
      od_restore = 1'b0;
      if (!bus_reset) begin
         if (st == ST_CMD && cmd_done) begin
            od_save  = (cmd_byte == OP_MATCH) || (cmd_byte == OP_OD_MATCH);
            od_raise = (cmd_byte == OP_OD_MATCH) || (cmd_byte == OP_OD_SKIP);
         end
         if (st == ST_MATCH && rx_valid && rx_bit != id_bit)
            od_restore = 1'b1;
      end
   end

   if (HAS_OD) begin : g_od
      logic od_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            overdrive <= 1'b0;
            od_prev   <= 1'b0;
         end else if (bus_reset) begin
            if (reset_long) overdrive <= 1'b0;
         end else begin
            if (od_save) od_prev <= overdrive;
            if (od_raise) overdrive <= 1'b1;
            else if (od_restore) overdrive <= od_prev;
         end
      end
   end else begin : g_no_od
      assign overdrive = 1'b0;
   end

   // command and addressing sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_CMD;
         ph       <= PH_SEND;
         idx      <= '0;
         rc       <= 1'b0;
         selected <= 1'b0;
      end else if (bus_reset) begin
         st       <= ST_CMD;
         ph       <= PH_SEND;
         idx      <= '0;
         selected <= 1'b0;
      end else begin
         case (st)
            ST_CMD: if (cmd_done) begin
               idx <= '0;
               ph  <= PH_SEND;
               case (cmd_byte)
                  OP_READ_ID: begin st <= ST_READ;   rc <= 1'b0; end
                  OP_MATCH:   begin st <= ST_MATCH;  rc <= 1'b0; end
                  OP_SEARCH:  begin st <= ST_SEARCH; rc <= 1'b0; end
                  OP_SKIP: begin
                     st <= ST_SEL; selected <= 1'b1; rc <= 1'b0;
                  end
                  OP_RESUME: begin
                     if (rc) begin st <= ST_SEL; selected <= 1'b1; end
                     else st <= ST_IDLE;
                  end
                  OP_OD_SKIP: begin
                     if (HAS_OD) begin
                        st <= ST_SEL; selected <= 1'b1; rc <= 1'b0;
                     end else st <= ST_IDLE;
                  end
                  OP_OD_MATCH: begin
                     if (HAS_OD) begin st <= ST_MATCH; rc <= 1'b0; end
                     else st <= ST_IDLE;
                  end
                  default: st <= ST_IDLE;
               endcase
            end
            ST_READ: if (rd_slot) begin
               if (idx_last) begin
                  st <= ST_SEL; selected <= 1'b1; rc <= 1'b1;
               end else idx <= idx + 1'b1;
            end
            ST_MATCH: if (rx_valid) begin
               if (rx_bit != id_bit) st <= ST_IDLE;
               else if (idx_last) begin
                  st <= ST_SEL; selected <= 1'b1; rc <= 1'b1;
               end else idx <= idx + 1'b1;
            end
            ST_SEARCH: begin
               case (ph)
                  PH_SEND: if (rd_slot) ph <= PH_CMPL;
                  PH_CMPL: if (rd_slot) ph <= PH_RECV;
                  default: if (rx_valid) begin
                     if (rx_bit != id_bit) st <= ST_IDLE;
                     else if (idx_last) begin
                        st <= ST_SEL; selected <= 1'b1; rc <= 1'b1;
                     end else begin
                        idx <= idx + 1'b1;
                        ph  <= PH_SEND;
                     end
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      tx_bit = 1'b1;
      if (st == ST_READ) tx_bit = id_bit;
      else if (st == ST_SEARCH && ph == PH_SEND) tx_bit = id_bit;
      else if (st == ST_SEARCH && ph == PH_CMPL) tx_bit = !id_bit;
   end

   // R1
   reset_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> !selected);

   // R11
   long_reset_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_reset && reset_long) |=> !overdrive);

   // R8
   rc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset |=> (rc == $past(rc)));

   // R5
   search_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEARCH && ph == PH_SEND && rd_slot && !bus_reset)
      |=> (tx_bit == !$past(tx_bit)));

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !bus_reset) |=> (!selected && tx_bit));

endmodule

// File: tb/sim_owr_rom_layer.sv
`timescale 1ns/1ps
module sim_owr_rom_layer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_reset = 1'b0;
   logic        reset_long = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_bit = 1'b0;
   logic        rd_slot = 1'b0;
   logic [55:0] body = 56'hA1B2C3D4E5F644;
   logic        tx_bit, selected, overdrive;
   logic [63:0] exp_id;
   int          checks = 0;
   int          errors = 0;
   bit          done_flag = 1'b0;

   always #10 clk = ~clk;

   owr_rom_layer u0 (
      .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reset_long(reset_long),
      .rx_valid(rx_valid), .rx_bit(rx_bit), .rd_slot(rd_slot), .rom_id_in(body),
      .tx_bit(tx_bit), .selected(selected), .overdrive(overdrive)
   );

   function automatic logic [7:0] crc8_ref(input logic [55:0] d);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         logic fb = c[0] ^ d[i];
         c = c >> 1;
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_rst(input bit long_w);
      @(negedge clk); bus_reset = 1'b1; reset_long = long_w;
      @(negedge clk); bus_reset = 1'b0; reset_long = 1'b0;
   endtask

   task automatic wr_bit(input bit b);
      @(negedge clk); rx_valid = 1'b1; rx_bit = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) wr_bit(v[i]);
   endtask

   task automatic rd_bit(output bit b);
      @(negedge clk); b = tx_bit; rd_slot = 1'b1;
      @(negedge clk); rd_slot = 1'b0;
   endtask

   task automatic wr_id(input logic [63:0] v);
      for (int i = 0; i < 64; i++) wr_bit(v[i]);
   endtask

   task automatic t_por;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(selected == 0 && tx_bit == 1 && overdrive == 0, "R1 por", {selected, tx_bit, overdrive}, 3'b010);
   endtask

   task automatic t_read;
      logic [63:0] got;
      bit b;
      bus_rst(1);
      wr_byte(8'h33);
      for (int i = 0; i < 64; i++) begin rd_bit(b); got[i] = b; end
      chk(got == exp_id, "R2 read id", got, exp_id);
      chk(got[63:56] == crc8_ref(body) && got[55:0] == body, "R3 crc byte", got, exp_id);
      chk(selected == 1, "R2 selected after read", selected, 1);
      bus_rst(0);
      chk(selected == 0 && tx_bit == 1, "R1 deselect on reset", {selected, tx_bit}, 2'b01);
      wr_byte(8'hA5);
      chk(selected == 1, "R7 R8 resume after read", selected, 1);
   endtask

   task automatic t_match;
      bit b;
      bus_rst(1); wr_byte(8'h55); wr_id(exp_id);
      chk(selected == 1, "R4 match ok", selected, 1);
      bus_rst(1); wr_byte(8'h55); wr_id(exp_id ^ (64'd1 << 63));
      chk(selected == 0, "R4 match last-bit mismatch", selected, 0);
      rd_bit(b);
      chk(b == 1, "R4 silent after mismatch", b, 1);
      bus_rst(1); wr_byte(8'hA5);
      chk(selected == 0, "R7 resume after failed match", selected, 0);
   endtask

   task automatic t_search;
      bit b0, b1, okr;
      okr = 1;
      bus_rst(1); wr_byte(8'hF0);
      for (int i = 0; i < 64; i++) begin
         rd_bit(b0); rd_bit(b1);
         if (b0 != exp_id[i] || b1 != !exp_id[i]) okr = 0;
         wr_bit(exp_id[i]);
      end
      chk(okr, "R5 search bit and complement", okr, 1);
      chk(selected == 1, "R5 search select", selected, 1);
      bus_rst(1); wr_byte(8'hF0);
      for (int i = 0; i < 10; i++) begin rd_bit(b0); rd_bit(b1); wr_bit(exp_id[i]); end
      rd_bit(b0); rd_bit(b1);
      wr_bit(!exp_id[10]);
      rd_bit(b0); rd_bit(b1);
      chk(b0 == 1 && b1 == 1 && selected == 0, "R5 dropped out", {b0, b1, selected}, 3'b110);
   endtask

   task automatic t_skip;
      bus_rst(1); wr_byte(8'h55); wr_id(exp_id);
      bus_rst(1); wr_byte(8'hCC);
      chk(selected == 1, "R6 skip selects", selected, 1);
      bus_rst(1); wr_byte(8'hA5);
      chk(selected == 0, "R6 R7 skip cleared resume", selected, 0);
   endtask

   task automatic t_unknown;
      bit b;
      bus_rst(1); wr_byte(8'h99);
      wr_byte(8'hCC);
      rd_bit(b);
      chk(selected == 0 && b == 1, "R12 unknown ignored", {selected, b}, 2'b01);
   endtask

   task automatic t_od;
      bus_rst(1); wr_byte(8'h3C);
      chk(selected == 1 && overdrive == 1, "R9 od skip", {selected, overdrive}, 2'b11);
      bus_rst(0);
      chk(overdrive == 1 && selected == 0, "R11 short reset keeps od", {overdrive, selected}, 2'b10);
      bus_rst(1);
      chk(overdrive == 0, "R11 long reset clears od", overdrive, 0);
      wr_byte(8'h69);
      chk(overdrive == 1 && selected == 0, "R10 od set on command", {overdrive, selected}, 2'b10);
      wr_id(exp_id);
      chk(overdrive == 1 && selected == 1, "R10 od match ok", {overdrive, selected}, 2'b11);
      bus_rst(1); wr_byte(8'h69); wr_bit(!exp_id[0]);
      chk(overdrive == 0 && selected == 0, "R10 mismatch restores od=0", {overdrive, selected}, 2'b00);
      bus_rst(1); wr_byte(8'h3C); bus_rst(0);
      wr_byte(8'h69); wr_id(exp_id ^ 64'h0000_0100_0000_0000);
      chk(overdrive == 1 && selected == 0, "R10 mismatch keeps od=1", {overdrive, selected}, 2'b10);
   endtask

   task automatic t_por_rc;
      bus_rst(1); wr_byte(8'h55); wr_id(exp_id);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      wr_byte(8'hA5);
      chk(selected == 0, "R8 rst_n clears resume flag", selected, 0);
   endtask

   initial begin
      exp_id = {crc8_ref(body), body};
      t_por();
      t_read();
      t_match();
      t_search();
      t_skip();
      t_unknown();
      t_od();
      t_por_rc();
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done_flag) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule